// File: doc/BRIEF.md
# MDIO Management Master with Register Control

This block lets a processor drive a Clause-22 management bus through two 32-bit registers. The control register holds the MDC divider, a preamble enable and a read-only busy flag. The command register is laid out exactly like the serial frame: start, opcode, PHY address, register address, turnaround and data. Writing the command register while the block is idle starts one frame. The engine sends an optional 32-bit preamble of ones and then the 32 command bits, most significant bit first. It generates MDC itself and controls the MDIO output enable.

For a read frame, the master stops driving MDIO from the first turnaround bit to the end of the frame. It samples the 16 bits returned by the PHY on rising MDC edges and places them in the low half of the command register when busy clears. Software polls busy before it issues the next command. A command written while busy is set is dropped.

Top module: `mdio_master`

## Requirements
- R1: After reset, busy is 0, MDC is low, MDIO is released (output enable 0), and the divider, preamble enable and command register all read as 0.
- R2: Byte offset 0x0 is the control register: divider in bits 6:0, preamble enable in bit 7, busy in bit 8 (read-only), all other bits read 0. Byte offset 0x4 is the command register and reads back its stored 32-bit value.
- R3: A write to offset 0x4 while busy is 0 stores the word, sets busy on the next clock edge and drives the first bit of the frame at once.
- R4: While busy, MDC has a period of 2×(divider+1) clocks: low for divider+1 clocks, then high for divider+1 clocks. MDC is held low while idle.
- R5: With preamble enabled, 32 ones are sent before command bit 31. With it disabled, the frame begins with bit 31.
- R6: Command bits go out from bit 31 down to bit 0, one bit per MDC period. MDIO only changes at a falling MDC edge (or at launch), so it is stable while MDC is high.
- R7: When bits 29:28 equal binary 10 (read), the output enable is 0 for command bits 17 down to 0. Any other opcode value drives all 32 bits.
- R8: On a read, MDIO is sampled at each rising MDC edge of command-bit positions 15..0, MSB first. When busy clears, command register bits 15:0 hold the sampled word and bits 31:16 keep the written command.
- R9: A write to offset 0x4 while busy is 1 has no effect, including a write in the very cycle the frame completes.
- R10: The output enable is 0 whenever busy is 0.
- R11: Busy clears at the falling MDC edge that ends the last bit, so it stays set for (32 or 64)×2×(divider+1) clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mdio_i | input | 1 | MDIO input from the pad |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (0 = released) |

## Verification
Two events can land in the same clock edge. One is the completion of a read frame, which loads the captured PHY word into the command register. The other is a software write to that register, which must be dropped because busy is still set in that cycle. The bench provokes this by holding a write of a second command asserted across the end of a read frame. It checks that the register shows the captured word for exactly one cycle and then shows the second command. A responder model then checks that the second frame on the wire matches the second command.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int REG_W          = 32;
    localparam int FRAME_LEN      = 32;
    localparam int PRE_LEN        = 32;
    localparam int IDX_W          = $clog2(FRAME_LEN + PRE_LEN);
    localparam int CTRL_OFS       = 0;
    localparam int DATA_OFS       = 4;
    localparam int PRE_BIT        = 7;
    localparam int BUSY_BIT       = 8;
    localparam int RD_W           = 16;
    // frame positions counted from the first command bit (bit 31)
    localparam int RELEASE_POS    = 14;
    localparam int SAMPLE_POS     = 16;
    localparam logic [1:0] OP_READ = 2'b10;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } cg_t;

    cg_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        rise_stb = 1'b0;
        fall_stb = 1'b0;
        if (!run) begin
            st_d.cnt = '0;
            st_d.mdc = 1'b0;
        end else if (st_q.cnt == div) begin
            st_d.cnt = '0;
            st_d.mdc = ~st_q.mdc;
            rise_stb = ~st_q.mdc;
            fall_stb = st_q.mdc;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mdc = st_q.mdc;
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [REG_W-1:0] cmd,
    input  logic             pre_en,
    input  logic             rise_stb,
    input  logic             fall_stb,
    input  logic             mdio_i,
    output logic             busy,
    output logic             done,
    output logic             rd_valid,
    output logic [RD_W-1:0]  rd_data,
    output logic             mdio_o,
    output logic             mdio_oe
);
    localparam logic [IDX_W-1:0] PRE_OFS = IDX_W'(PRE_LEN);

    typedef struct packed {
        logic             busy;
        logic             pre;
        logic [REG_W-1:0] cmd;
        logic [IDX_W-1:0] idx;
        logic [RD_W-1:0]  cap;
    } eng_t;

    eng_t st_d, st_q;

    logic [IDX_W-1:0] last_idx;
    logic [IDX_W-1:0] fpos;
    logic [4:0]       bit_sel;
    logic             in_pre;
    logic             is_read;
    logic             released;

    always_comb begin
        last_idx = st_q.pre ? IDX_W'(PRE_LEN + FRAME_LEN - 1) : IDX_W'(FRAME_LEN - 1);
        in_pre   = st_q.pre && (st_q.idx < PRE_OFS);
        fpos     = st_q.idx - (st_q.pre ? PRE_OFS : '0);
        bit_sel  = 5'd31 - fpos[4:0];
        is_read  = (st_q.cmd[29:28] == OP_READ);
        released = is_read && !in_pre && (fpos >= IDX_W'(RELEASE_POS));
    end

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.pre  = pre_en;
                st_d.cmd  = cmd;
                st_d.idx  = '0;
                st_d.cap  = '0;
            end
        end else begin
            if (rise_stb && is_read && !in_pre && (fpos >= IDX_W'(SAMPLE_POS))) begin
                st_d.cap = {st_q.cap[RD_W-2:0], mdio_i};
            end
            if (fall_stb) begin
                if (st_q.idx == last_idx) begin
                    st_d.busy = 1'b0;
                    done      = 1'b1;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy     = st_q.busy;
    assign rd_valid = done && is_read;
    assign rd_data  = st_q.cap;
    assign mdio_o   = !st_q.busy ? 1'b1 : (in_pre ? 1'b1 : st_q.cmd[bit_sel]);
    assign mdio_oe  = st_q.busy && !released;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W  = 7,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              mdio_i,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe
);
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             pre;
        logic [REG_W-1:0] data;
    } regs_t;

    regs_t st_d, st_q;

    logic             sel_ctrl, sel_data;
    logic             we_ctrl, we_data;
    logic             start;
    logic             busy, eng_done, rd_valid;
    logic [RD_W-1:0]  rd_data;
    logic             rise_stb, fall_stb;
    logic [REG_W-1:0] data_reg;

    assign sel_ctrl = (reg_addr == ADDR_W'(CTRL_OFS));
    assign sel_data = (reg_addr == ADDR_W'(DATA_OFS));
    assign we_ctrl  = reg_we && sel_ctrl;
    assign we_data  = reg_we && sel_data;
    assign start    = we_data && !busy;
    assign data_reg = st_q.data;

    always_comb begin
        st_d = st_q;
        if (we_ctrl) begin
            st_d.div = reg_wdata[DIV_W-1:0];
            st_d.pre = reg_wdata[PRE_BIT];
        end
        if (start) begin
            st_d.data = reg_wdata;
        end else if (rd_valid) begin
            st_d.data[RD_W-1:0] = rd_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (sel_ctrl) begin
            reg_rdata[DIV_W-1:0] = st_q.div;
            reg_rdata[PRE_BIT]   = st_q.pre;
            reg_rdata[BUSY_BIT]  = busy;
        end else if (sel_data) begin
            reg_rdata = st_q.data;
        end
    end

    mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .div      (st_q.div),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_engine u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cmd      (reg_wdata),
        .pre_en   (st_q.pre),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .done     (eng_done),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        we_data,
    input logic [31:0] data_reg,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    p_idle_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);

    p_mdc_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    p_launch_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we_data && !busy) |=> busy);

    p_drop_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (we_data && busy && !done) |=> $stable(data_reg));

    p_hold_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    p_end_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (eng_done),
    .we_data  (we_data),
    .data_reg (data_reg),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mdio_i = 1'b1;
    logic        mdc, mdio_o, mdio_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    typedef struct {
        bit          pre;
        int          div;
        logic [31:0] cmd;
        logic [15:0] phy;
    } item_t;

    item_t sb_q[$];

    always #10 clk = ~clk;

    mdio_master u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdio_i    (mdio_i),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] phy,
                                       input logic [4:0] rg, input logic [15:0] d);
        return {1'b0, 1'b1, op, phy, rg, 2'b10, d};
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 4'd0;
    endtask

    // monitor and PHY responder: checks each frame against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mdio_oe) begin
                item_t it;
                int nb, off, k, lowc, highc, fp, bits_bad, oe_bad, tim_bad;
                logic pm, eb, rd;
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R3", "frame without command", 32'd1, 32'd0);
                    it = '{pre: 1'b0, div: 0, cmd: 32'd0, phy: 16'd0};
                end else begin
                    it = sb_q.pop_front();
                end
                nb = it.pre ? 64 : 32;
                off = it.pre ? 32 : 0;
                rd = (it.cmd[29:28] == 2'b10);
                k = 0; lowc = 1; highc = 0; pm = 1'b0;
                bits_bad = 0; oe_bad = 0; tim_bad = 0;
                mdio_i = 1'b1;
                while (k < nb) begin
                    @(negedge clk);
                    if (mdc && !pm) begin
                        if (lowc != it.div + 1) tim_bad++;
                        fp = k - off;
                        eb = (k < off) ? 1'b1 : it.cmd[31 - fp];
                        if (rd && k >= off && fp >= 14) begin
                            if (mdio_oe) oe_bad++;
                        end else if (!mdio_oe || mdio_o !== eb) begin
                            bits_bad++;
                        end
                        highc = 1;
                    end else if (!mdc && pm) begin
                        if (highc != it.div + 1) tim_bad++;
                        k++;
                        lowc = 1;
                        fp = k - off;
                        mdio_i = (rd && k < nb && k >= off && fp >= 16) ? it.phy[31 - fp] : 1'b1;
                    end else if (mdc) begin
                        highc++;
                    end else begin
                        lowc++;
                    end
                    pm = mdc;
                end
                mdio_i = 1'b1;
                chk(bits_bad == 0, it.pre ? "R5/R6" : "R6", "serial bit errors", bits_bad, 0);
                chk(oe_bad == 0, "R7", "enable not released", oe_bad, 0);
                chk(tim_bad == 0, "R4", "MDC half-period errors", tim_bad, 0);
                chk(!mdio_oe && !mdc, "R10", "bus after frame {oe,mdc}",
                    {30'd0, mdio_oe, mdc}, 32'd0);
            end
        end
    end

    // driver: program, push expected item, launch, poll busy
    task automatic run_frame(input bit pre, input int div, input logic [31:0] cmd,
                             input logic [15:0] phy, input bit inject);
        int cnt, nb;
        logic [31:0] exp;
        wr(4'h0, {24'd0, pre, 7'(div)});
        #1 chk(reg_rdata == {24'd0, pre, 7'(div)}, "R2", "control readback",
               reg_rdata, {24'd0, pre, 7'(div)});
        sb_q.push_back('{pre: pre, div: div, cmd: cmd, phy: phy});
        wr(4'h4, cmd);
        nb = pre ? 64 : 32;
        cnt = 0;
        forever begin
            if (inject && cnt == 5) begin
                reg_we = 1'b1; reg_addr = 4'h4; reg_wdata = ~cmd;
                cnt++;
                @(negedge clk);
                reg_we = 1'b0; reg_addr = 4'h0;
            end
            #1;
            if (!reg_rdata[8]) break;
            cnt++;
            @(negedge clk);
        end
        chk(cnt == nb * 2 * (div + 1), "R11", "busy length", cnt, nb * 2 * (div + 1));
        exp = (cmd[29:28] == 2'b10) ? {cmd[31:16], phy} : cmd;
        reg_addr = 4'h4;
        #1 chk(reg_rdata == exp, (cmd[29:28] == 2'b10) ? "R8" : (inject ? "R9" : "R3"),
               "command register after frame", reg_rdata, exp);
        reg_addr = 4'h0;
    endtask

    task automatic wait_idle();
        forever begin
            @(negedge clk);
            reg_addr = 4'h0;
            #1;
            if (!reg_rdata[8]) break;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] a_cmd, b_cmd, prev, v, capv;
        int seen_cap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        reg_addr = 4'h0;
        #1 chk(reg_rdata == 32'd0, "R1", "control after reset", reg_rdata, 0);
        reg_addr = 4'h4;
        #1 chk(reg_rdata == 32'd0, "R1", "command after reset", reg_rdata, 0);
        chk(!mdc && !mdio_oe, "R1", "bus after reset {mdc,oe}", {30'd0, mdc, mdio_oe}, 0);
        // R2: read-only busy and unused control bits
        wr(4'h0, 32'hFFFF_FFFF);
        #1 chk(reg_rdata == 32'h0000_00FF, "R2", "control masking", reg_rdata, 32'hFF);
        // R3/R4/R6: plain write frame
        run_frame(1'b0, 0, mk(2'b01, 5'd5, 5'd3, 16'hA5C3), 16'h0000, 1'b0);
        // R5/R7/R8: read with preamble
        run_frame(1'b1, 1, mk(2'b10, 5'd17, 5'd2, 16'h0000), 16'h1234, 1'b0);
        // R9: write while busy is dropped
        run_frame(1'b0, 3, mk(2'b10, 5'd1, 5'd30, 16'h0000), 16'hBEEF, 1'b1);
        // R4/R5: typical divider with preamble
        run_frame(1'b1, 26, mk(2'b01, 5'd31, 5'd31, 16'h0F0F), 16'h0000, 1'b0);
        // R7: other opcode drives whole frame
        run_frame(1'b0, 2, mk(2'b11, 5'd9, 5'd12, 16'h5AA5), 16'hFFFF, 1'b0);
        // R9/R8 collision: write held across read completion
        wr(4'h0, 32'd0);
        a_cmd = mk(2'b10, 5'd6, 5'd7, 16'h0000);
        b_cmd = mk(2'b01, 5'd10, 5'd11, 16'h3C3C);
        capv  = {a_cmd[31:16], 16'hC0DE};
        sb_q.push_back('{pre: 1'b0, div: 0, cmd: a_cmd, phy: 16'hC0DE});
        sb_q.push_back('{pre: 1'b0, div: 0, cmd: b_cmd, phy: 16'h0000});
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'h4; reg_wdata = a_cmd;
        @(negedge clk);
        reg_wdata = b_cmd;
        prev = 32'd0; seen_cap = 0;
        forever begin
            #1 v = reg_rdata;
            if (v == b_cmd) break;
            if (v == capv) seen_cap++;
            prev = v;
            @(negedge clk);
        end
        reg_we = 1'b0; reg_addr = 4'h0;
        chk(prev == capv, "R9", "value before held write lands", prev, capv);
        chk(seen_cap == 1, "R9", "cycles showing captured word", seen_cap, 1);
        wait_idle();
        reg_addr = 4'h4;
        #1 chk(reg_rdata == b_cmd, "R3", "second command kept", reg_rdata, b_cmd);
        reg_addr = 4'h0;
        repeat (4) @(negedge clk);
        chk(sb_q.size() == 0, "R3", "frames left unseen", sb_q.size(), 0);
        chk(!mdio_oe && !mdc, "R10", "idle bus at end", {30'd0, mdio_oe, mdc}, 0);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule